// File: doc/BRIEF.md
# Three-State Mealy String Evaluator

This block runs a fixed three-state Mealy machine over a binary word supplied in parallel. A one-cycle start pulse captures the word and a length, and puts the machine back in its initial state R. From the next clock on, the block consumes one bit per cycle, beginning with the least significant bit. For each transition it raises a one-cycle strobe carrying the output symbol of that transition.

The three states are R, S and T, and T is the terminal state. When the last bit of the word has been consumed, the block pulses done. It also presents the final state, the symbol of the last transition, and a flag that is set when the final state is T. These results stay stable until the next start.

A start pulse that arrives while a word is still being evaluated abandons that word and begins the new one from R. The transition table is irregular and fixed; it is not a programmable sequence recogniser.

Top module: `mealy_eval`

## Requirements
- R1: State codes are R=2'b00, S=2'b01, T=2'b10. Symbol codes are alpha=2'b00, beta=2'b01, gamma=2'b10. A start pulse puts the machine in R, and no emitted symbol uses code 2'b11.
- R2: From R, bit 0 moves to S and emits alpha. Bit 1 moves to T and emits beta.
- R3: From S, bit 0 moves to R and emits beta. Bit 1 stays in S and emits gamma.
- R4: From T, bit 0 stays in T and emits alpha. Bit 1 moves to R and emits alpha.
- R5: Bits are consumed from bit 0 upward, one per clock. The first stepValid comes two cycles after the start cycle, and there are exactly as many stepValid pulses as the length.
- R6: inTerminal is 1 exactly when finalState is T. The word 6'b100101 with length 6 ends in T with last symbol beta.
- R7: done is a one-cycle pulse, in the same cycle as the last stepValid. finalState, lastOutput and inTerminal hold their values until the next start.
- R8: A length of zero gives done in the cycle after start, with finalState R, lastOutput alpha and inTerminal 0.
- R9: A start during evaluation abandons the current word, with no done for it, and evaluates the new word from R.
- R10: A length above N is treated as N.
- R11: While reset is held, stepValid, done, inTerminal, finalState and lastOutput are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load word and length, restart from R |
| word | input | N | Input bits, bit 0 consumed first |
| len | input | $clog2(N+1) | Number of bits to consume |
| stepValid | output | 1 | One transition happened this cycle |
| stepSym | output | 2 | Symbol of that transition |
| done | output | 1 | Word finished (one-cycle pulse) |
| finalState | output | 2 | State after the last transition |
| lastOutput | output | 2 | Symbol of the last transition |
| inTerminal | output | 1 | finalState is T |

## Verification
The bench builds the block with N=6, so the length port is three bits wide. That lets the bench drive a length of 7 and observe the clamp to six steps. Six-bit words hold the 100101 example as well as short walks that visit every entry of the table. Random words and lengths, an abort after two steps, and the zero-length case are compared against an independent table model, symbol by symbol and at completion.

// File: rtl/mealy_eval_pkg.sv
package mealy_eval_pkg;

  typedef enum logic [1:0] {
    ST_R = 2'b00,
    ST_S = 2'b01,
    ST_T = 2'b10
  } state_t;

  typedef enum logic [1:0] {
    SYM_ALPHA = 2'b00,
    SYM_BETA  = 2'b01,
    SYM_GAMMA = 2'b10
  } sym_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } ctrl_t;

  typedef struct packed {
    state_t nxt;
    sym_t   sym;
  } move_t;

  // fixed Mealy table; any unused state code falls back to R
  function automatic move_t mealyMove(input state_t cur, input logic bitIn);
    move_t m;
    case (cur)
      ST_R:    m = bitIn ? '{nxt: ST_T, sym: SYM_BETA}  : '{nxt: ST_S, sym: SYM_ALPHA};
      ST_S:    m = bitIn ? '{nxt: ST_S, sym: SYM_GAMMA} : '{nxt: ST_R, sym: SYM_BETA};
      ST_T:    m = bitIn ? '{nxt: ST_R, sym: SYM_ALPHA} : '{nxt: ST_T, sym: SYM_ALPHA};
      default: m = '{nxt: ST_R, sym: SYM_ALPHA};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mealy_eval_ctrl.sv
module mealy_eval_ctrl
  import mealy_eval_pkg::*;
#(
  parameter int N  = 6,
  parameter int LW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [LW-1:0] len,
  output ctrl_t         ctrl,
  output logic          done,
  output logic          busy
);

  localparam logic [LW-1:0] MAX_LEN = LW'(N);

  logic [LW-1:0] remaining;
  logic [LW-1:0] lenClamped;

  always_comb begin
    lenClamped = (len > MAX_LEN) ? MAX_LEN : len;
  end

  always_comb begin
    ctrl.load = start;
    ctrl.step = busy && !start;
    ctrl.last = busy && !start && (remaining == LW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        remaining <= lenClamped;
        busy      <= (lenClamped != '0);
        done      <= (lenClamped == '0);
      end else if (ctrl.step) begin
        remaining <= remaining - LW'(1);
        if (ctrl.last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    remaining <= MAX_LEN);                                      // R10
  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (start && len == '0) |=> done);                             // R8
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);                                            // R7
  AST_BUSY_HAS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> remaining != '0);                                  // R5

endmodule

// File: rtl/mealy_eval_dp.sv
module mealy_eval_dp
  import mealy_eval_pkg::*;
#(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_t        ctrl,
  input  logic [N-1:0] word,
  output logic         stepValid,
  output sym_t         stepSym,
  output state_t       finalState,
  output sym_t         lastOutput,
  output logic         inTerminal
);

  logic [N-1:0] bitsLeft;
  state_t       curState;
  move_t        move;

  always_comb begin
    move = mealyMove(curState, bitsLeft[0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitsLeft   <= '0;
      curState   <= ST_R;
      stepValid  <= 1'b0;
      stepSym    <= SYM_ALPHA;
      finalState <= ST_R;
      lastOutput <= SYM_ALPHA;
      inTerminal <= 1'b0;
    end else begin
      stepValid <= 1'b0;
      if (ctrl.load) begin
        bitsLeft   <= word;
        curState   <= ST_R;
        finalState <= ST_R;
        lastOutput <= SYM_ALPHA;
        inTerminal <= 1'b0;
      end else if (ctrl.step) begin
        bitsLeft  <= bitsLeft >> 1;
        curState  <= move.nxt;
        stepValid <= 1'b1;
        stepSym   <= move.sym;
        if (ctrl.last) begin
          finalState <= move.nxt;
          lastOutput <= move.sym;
          inTerminal <= (move.nxt == ST_T);
        end
      end
    end
  end

  AST_TERM_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    inTerminal |-> finalState == ST_T);                         // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.last) |=> $stable({finalState, lastOutput, inTerminal})); // R7
  AST_STEP_CODE: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |-> stepSym != 2'b11);                            // R1
  AST_LOAD_TO_R: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> curState == ST_R);                            // R1

endmodule

// File: rtl/mealy_eval.sv
module mealy_eval
  import mealy_eval_pkg::*;
#(
  parameter  int N  = 6,
  localparam int LW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [N-1:0]  word,
  input  logic [LW-1:0] len,
  output logic          stepValid,
  output logic [1:0]    stepSym,
  output logic          done,
  output logic [1:0]    finalState,
  output logic [1:0]    lastOutput,
  output logic          inTerminal
);

  ctrl_t  ctrl;
  logic   busy;
  sym_t   stepSymT;
  state_t finalStateT;
  sym_t   lastOutputT;

  mealy_eval_ctrl #(.N(N), .LW(LW)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .len   (len),
    .ctrl  (ctrl),
    .done  (done),
    .busy  (busy)
  );

  mealy_eval_dp #(.N(N)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .word       (word),
    .stepValid  (stepValid),
    .stepSym    (stepSymT),
    .finalState (finalStateT),
    .lastOutput (lastOutputT),
    .inTerminal (inTerminal)
  );

  assign stepSym    = stepSymT;
  assign finalState = finalStateT;
  assign lastOutput = lastOutputT;

  AST_NO_STEP_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !stepValid);                                      // R9

endmodule

// File: tb/tb_mealy_eval.sv
`timescale 1ns/1ps
module tb_mealy_eval;
  localparam int N  = 6;
  localparam int LW = $clog2(N + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN, start;
  logic [N-1:0]  word;
  logic [LW-1:0] len;
  logic          stepValid, done, inTerminal;
  logic [1:0]    stepSym, finalState, lastOutput;

  mealy_eval #(.N(N)) dut (
    .clk(clk), .rstN(rstN), .start(start), .word(word), .len(len),
    .stepValid(stepValid), .stepSym(stepSym), .done(done),
    .finalState(finalState), .lastOutput(lastOutput), .inTerminal(inTerminal)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [1:0] symQ[$];
  logic [4:0] finQ[$];   // {state, symbol, terminal}
  logic [4:0] expFin;
  bit prevDone = 1'b0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // independent table: returns {next, symbol}
  function automatic logic [3:0] refMove(input logic [1:0] st, input logic b);
    case (st)
      2'b00:   return b ? {2'b10, 2'b01} : {2'b01, 2'b00};
      2'b01:   return b ? {2'b01, 2'b10} : {2'b00, 2'b01};
      2'b10:   return b ? {2'b00, 2'b00} : {2'b10, 2'b00};
      default: return {2'b00, 2'b00};
    endcase
  endfunction

  // push expected items for the first 'steps' bits
  task automatic pushExpect(input logic [N-1:0] w, input int steps, input bit withFinal);
    logic [1:0] st = 2'b00;
    logic [1:0] sy = 2'b00;
    logic [3:0] m;
    for (int i = 0; i < steps; i++) begin
      m = refMove(st, w[i]);
      st = m[3:2];
      sy = m[1:0];
      symQ.push_back(sy);
    end
    if (withFinal) begin
      expFin = {st, sy, st == 2'b10};
      finQ.push_back(expFin);
    end
  endtask

  // called at a negedge; returns at the negedge after start drops
  task automatic pulseStart(input logic [N-1:0] w, input int l);
    word  = w;
    len   = LW'(l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runWord(input logic [N-1:0] w, input int l, input string tag);
    int eff = (l > N) ? N : l;   // R10 clamp
    pushExpect(w, eff, 1'b1);
    pulseStart(w, l);
    repeat (eff + 3) @(negedge clk);
    check(finQ.size() == 0, {tag, " done seen"}, finQ.size(), 0);
    check(done == 1'b0, "R7 done is single pulse", done, 0);
    check({finalState, lastOutput, inTerminal} == expFin, "R7 results held",
          {finalState, lastOutput, inTerminal}, expFin);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic [1:0] e;
    logic [4:0] f;
    if (rstN) begin
      if (stepValid) begin
        if (symQ.size() == 0) check(1'b0, "R5 unexpected step", stepSym, -1);
        else begin
          e = symQ.pop_front();
          check(stepSym == e, "R5 step symbol", stepSym, e);
        end
      end
      if (done) begin
        check(!prevDone, "R7 done pulse width", prevDone, 0);
        check(symQ.size() == 0, "R7 done with last step", symQ.size(), 0);
        if (finQ.size() == 0) check(1'b0, "R9 unexpected done", 1, 0);
        else begin
          f = finQ.pop_front();
          check(finalState == f[4:3], "R6 final state", finalState, f[4:3]);
          check(lastOutput == f[2:1], "R6 last output", lastOutput, f[2:1]);
          check(inTerminal == f[0], "R6 terminal flag", inTerminal, f[0]);
        end
      end
      prevDone = done;
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog expired", 0, 1);
    finish();
  end

  initial begin
    rstN = 1'b0; start = 1'b0; word = '0; len = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(stepValid == 0, "R11 stepValid in reset", stepValid, 0);
    check(done == 0, "R11 done in reset", done, 0);
    check(inTerminal == 0, "R11 inTerminal in reset", inTerminal, 0);
    check(finalState == 0, "R11 finalState in reset", finalState, 0);
    check(lastOutput == 0, "R11 lastOutput in reset", lastOutput, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R6 worked example: ends in T with beta
    runWord(6'b100101, 6, "R6 example");
    check(finalState == 2'b10 && lastOutput == 2'b01, "R6 example T/beta",
          {finalState, lastOutput}, 4'b1001);
    // R2 R3: R-0->S, S-1->S, S-0->R
    runWord(6'b000010, 3, "R3 walk");
    // R2 R4: R-1->T, T-0->T, T-1->R
    runWord(6'b000101, 3, "R4 walk");
    runWord(6'b000000, 6, "R2 zeros");
    runWord(6'b111111, 6, "R2 ones");
    // R8 zero length
    runWord(6'b101010, 0, "R8 zero length");
    check(finalState == 0 && lastOutput == 0 && inTerminal == 0, "R8 zero-length results",
          {finalState, lastOutput, inTerminal}, 0);
    // R10 clamp of length 7 to 6
    runWord(6'b110100, 7, "R10 clamp");
    // R5 single bit
    runWord(6'b000001, 1, "R5 single");
    // R9 abort after two steps, then a fresh word from R
    pushExpect(6'b011011, 2, 1'b0);
    pulseStart(6'b011011, 6);
    repeat (2) @(negedge clk);
    runWord(6'b100101, 6, "R9 after abort");
    check(symQ.size() == 0, "R9 queue drained", symQ.size(), 0);
    // random words and lengths
    for (int k = 0; k < 40; k++) begin
      runWord(N'($urandom), int'($urandom_range(0, 7)), "R5 random");
    end
    finish();
  end
endmodule